// File: doc/BRIEF.md
# Per-Sample Selectable Output Rounder

This block is a single-stage rounding pipeline for a 13-bit result word. Each sample arrives with a 2-bit precision mode and a number-format flag. The block registers a rounded copy of the word one clock later. Rounding keeps 8, 10, 12 or all 13 significant bits. It works by adding one at the bit just below the new least significant bit and then forcing that bit and every bit under it to zero. The word therefore keeps its full 13-bit width, and its low bits read as zero instead of being dropped.

The mode and the format flag are registered on the same edge as the data. A sample is rounded with exactly the settings it arrived with, so a stream may change precision from one sample to the next without affecting any sample already captured. An increment that would carry out of the 13-bit range saturates and does not wrap. The saturation limit is the largest value of the sample's format (unsigned or two's complement) that is legal at the chosen precision.

Top module: `rounderTop`

## Requirements
- R1: Mode encoding sets the precision. Mode 2'b00 keeps 8 bits (increment at bit 4, bits 4..0 cleared). 2'b01 keeps 10 bits (increment at bit 2, bits 2..0 cleared). 2'b10 keeps 12 bits (increment at bit 0, bit 0 cleared).
- R2: The increment is a single one added at the bit position just under the kept LSB, so an input whose dropped part is at least half an output step rounds up, and otherwise rounds down.
- R3: In every valid output, the increment position and all bits below it are zero.
- R4: The mode and the format flag are registered together with the word. Each applies only to that sample, so back-to-back samples with different modes are each rounded by their own mode.
- R5: When the format flag is 0 (unsigned), a carry out of bit 12 saturates the result to 13'h1FFF with the cleared bits zero (for example 13'h1FE0 in mode 2'b00).
- R6: When the format flag is 1 (two's complement), a positive input that would round past 13'h0FFF saturates to 13'h0FFF with the cleared bits zero. Negative inputs round toward plus infinity without wrapping (for example 13'h1FFF in mode 2'b00 gives 13'h0000).
- R7: Latency is one clock cycle, and outValid equals inValid of the previous cycle.
- R8: When inValid is low, outWord keeps its previous value.
- R9: During reset, outValid is 0 and outWord is 13'h0000.
- R10: Mode 2'b11 keeps all 13 bits, and the word passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Sample qualifier |
| inWord | input | 13 | Word to be rounded |
| inMode | input | 2 | Precision mode for this sample |
| inTwosComp | input | 1 | 1: two's complement sample, 0: unsigned |
| outValid | output | 1 | Qualifier for outWord |
| outWord | output | 13 | Rounded, saturated word |

## Verification
The bench builds the block with its default kept widths of 8, 10, 12 and 13 bits. With these widths there are increment positions at bits 4, 2 and 0 as well as a pass-through mode, so every kind of rounding step can be checked against a reference model that uses whole-number arithmetic. Inputs placed at the top of the unsigned and signed ranges reach both saturation limits. Streams whose mode changes on every cycle show that each sample keeps its own settings.

// File: rtl/rounderPkg.sv
package rounderPkg;
  localparam int unsigned WORD_W = 13;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned NUM_MODES = 1 << MODE_W;

  typedef logic [WORD_W-1:0] word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;
    logic  twosComp;
    word_t addend;
    word_t clearMask;
  } rndStrobe_t;
endpackage

// File: rtl/rounderCtrl.sv
module rounderCtrl
  import rounderPkg::*;
#(
  parameter int unsigned KEEP_BITS [NUM_MODES] = '{8, 10, 12, 13}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [MODE_W-1:0] inMode,
  input  logic              inTwosComp,
  output rndStrobe_t        strb,
  output logic              outValid
);
  word_t addTab  [NUM_MODES];
  word_t maskTab [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int unsigned DROP = WORD_W - KEEP_BITS[m];
    if (DROP == 0) begin : g_pass
      assign addTab[m]  = '0;
      assign maskTab[m] = '0;
    end else begin : g_round
      assign addTab[m]  = word_t'(1) << (DROP - 1);
      assign maskTab[m] = (word_t'(1) << DROP) - word_t'(1);
    end
  end

  always_comb begin
    strb.load      = inValid;
    strb.twosComp  = inTwosComp;
    strb.addend    = addTab[inMode];
    strb.clearMask = maskTab[inMode];
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid)));
endmodule

// File: rtl/rounderPath.sv
module rounderPath
  import rounderPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  word_t      inWord,
  input  rndStrobe_t strb,
  input  logic       outValid,
  output word_t      outWord
);
  logic [WORD_W:0] sum;
  logic            ovf;
  word_t           satVal;
  word_t           rounded;
  word_t           nextWord;

  always_comb begin
    sum     = {1'b0, inWord} + {1'b0, strb.addend};
    rounded = sum[WORD_W-1:0] & ~strb.clearMask;
    if (strb.twosComp) begin
      ovf    = !inWord[WORD_W-1] && sum[WORD_W-1];
      satVal = {1'b0, {(WORD_W-1){1'b1}}} & ~strb.clearMask;
    end else begin
      ovf    = sum[WORD_W];
      satVal = {WORD_W{1'b1}} & ~strb.clearMask;
    end
    nextWord = ovf ? satVal : rounded;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          outWord <= '0;
    else if (strb.load) outWord <= nextWord;
  end

  assert_low_cleared_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && outValid) |-> ((outWord & $past(strb.clearMask)) == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strb.load)) |-> $stable(outWord));

  assert_unsigned_no_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && outValid && !$past(strb.twosComp))
      |-> (outWord >= ($past(inWord) & ~$past(strb.clearMask))));
endmodule

// File: rtl/rounderTop.sv
module rounderTop
  import rounderPkg::*;
#(
  parameter int unsigned KEEP_BITS [NUM_MODES] = '{8, 10, 12, 13}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic [MODE_W-1:0] inMode,
  input  logic              inTwosComp,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord
);
  rndStrobe_t strb;

  rounderCtrl #(.KEEP_BITS(KEEP_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .inTwosComp(inTwosComp), .strb(strb), .outValid(outValid)
  );

  rounderPath u_path (
    .clk(clk), .rstN(rstN), .inWord(inWord), .strb(strb),
    .outValid(outValid), .outWord(outWord)
  );

  assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && inValid && inMode == MODE_W'(NUM_MODES - 1))
      |-> (outWord == $past(inWord)));

  assert_reset_R9: assert property (@(posedge clk)
    $past(!rstN) |-> (!outValid && outWord == '0));
endmodule

// File: tb/rounderTop_bench.sv
module rounderTop_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [12:0] inWord = '0;
  logic [1:0]  inMode = '0;
  logic        inTwosComp = 1'b0;
  logic        outValid;
  logic [12:0] outWord;

  int total = 0;
  int bad = 0;
  logic [12:0] lastExp = '0;

  always #10 clk = ~clk;

  rounderTop u_rounderTop (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inMode(inMode), .inTwosComp(inTwosComp),
    .outValid(outValid), .outWord(outWord)
  );

  function automatic logic [12:0] model(input logic [12:0] w, input logic [1:0] m,
                                        input logic tc);
    int drop, half, step, r, s;
    case (m)
      2'b00: drop = 5;
      2'b01: drop = 3;
      2'b10: drop = 1;
      default: drop = 0;
    endcase
    if (drop == 0) return w;
    step = 1 << drop;
    half = step / 2;
    if (tc) begin
      s = (w >= 13'd4096) ? int'(w) - 8192 : int'(w);
      r = ((s + half) >>> drop) * step;
      if (r > 4095) r = 4096 - step;
      return 13'(r);
    end
    r = ((int'(w) + half) / step) * step;
    if (r > 8191) r = 8192 - step;
    return 13'(r);
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check one cycle later at next negedge
  task automatic push(input string req, input logic [12:0] w, input logic [1:0] m,
                      input logic tc);
    inValid = 1'b1; inWord = w; inMode = m; inTwosComp = tc;
    @(negedge clk);
    lastExp = model(w, m, tc);
    check(req, outWord, lastExp);
    check({req, "/R7 valid"}, {12'd0, outValid}, 13'd1);
  endtask

  task automatic testReset();
    check("R9 outValid", {12'd0, outValid}, 13'd0);
    check("R9 outWord", outWord, 13'd0);
  endtask

  task automatic testModes();
    push("R1 m00", 13'h0123, 2'b00, 1'b0);
    push("R1 m01", 13'h0123, 2'b01, 1'b0);
    push("R1 m10", 13'h0123, 2'b10, 1'b0);
    push("R10 m11", 13'h0123, 2'b11, 1'b0);
    push("R10 m11 signed", 13'h1ABC, 2'b11, 1'b1);
  endtask

  task automatic testHalfPoint();
    push("R2 below half", 13'h002F, 2'b00, 1'b0);
    push("R2 at half", 13'h0030, 2'b00, 1'b0);
    push("R2 m01 half", 13'h0104, 2'b01, 1'b0);
    push("R3 m10 odd", 13'h0FFF, 2'b10, 1'b0);
  endtask

  task automatic testSaturate();
    push("R5 unsigned m00", 13'h1FF0, 2'b00, 1'b0);
    push("R5 unsigned m10", 13'h1FFF, 2'b10, 1'b0);
    push("R6 signed pos m00", 13'h0FF0, 2'b00, 1'b1);
    push("R6 signed pos m01", 13'h0FFC, 2'b01, 1'b1);
    push("R6 signed neg m00", 13'h1FFF, 2'b00, 1'b1);
    push("R6 signed neg m01", 13'h1003, 2'b01, 1'b1);
    push("R6 signed most neg", 13'h1000, 2'b00, 1'b1);
  endtask

  task automatic testStream();
    for (int i = 0; i < 24; i++) begin
      logic [12:0] w;
      w = 13'((i * 1237 + 91) % 8192);
      push("R4 stream", w, 2'(i % 4), 1'(i / 3 % 2));
    end
  endtask

  task automatic testHold();
    inValid = 1'b0; inWord = 13'h1555; inMode = 2'b00; inTwosComp = 1'b0;
    @(negedge clk);
    check("R8 hold", outWord, lastExp);
    check("R7 valid low", {12'd0, outValid}, 13'd0);
    @(negedge clk);
    check("R8 hold 2", outWord, lastExp);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        testReset();
        rstN = 1'b1;
        @(negedge clk);
        testModes();
        testHalfPoint();
        testSaturate();
        testHold();
        testStream();
        testHold();
      end
      begin
        repeat (5000) @(negedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule